// File: doc/BRIEF.md
# Stage 2-5 Execution Datapath

This block is the data side of a simple five-step processor, covering everything between instruction decode and register write-back. A register file with two read ports and one write port feeds a chain of always-loading pipeline registers: two operand latches, an ALU result latch, a store-data latch and a write-back latch. The control unit supplies the register numbers and the 16-bit immediate taken from the instruction word. It also supplies a function code for the ALU, a choice between a register operand and the immediate, and a choice of write-back source. The block returns an effective address, the data to store and an equality flag for branch decisions.

In use, the control unit presents each step's controls in the cycle where that step happens. The addresses of the source registers are sampled at the end of the decode step. The ALU inputs and the immediate apply during the execute step. The result select and memory read data apply during the memory step. The destination number and write enable apply during the write-back step. Sequencing, the program counter and the memory sit outside.

Top module: `rsd_datapath`

## Requirements
- R1: While `rst_n` is low, every pipeline latch and every register of the file clears to zero, so after reset `mem_addr` and `store_data` read 0 and `eq_flag` reads 1.
- R2: Two source registers, chosen by `src_a_sel` and `src_b_sel`, are read in the same cycle and latched into the operand latches at the next rising edge. The write-back latch is written into register `dst_sel` at a rising edge where `wr_en` is high.
- R3: With `wr_en` low, no register of the file changes, whatever `dst_sel` and the write-back latch hold.
- R4: A read of the register that is being written at the same edge captures the old contents; the new contents are seen from the next edge on.
- R5: Register 0 holds any written value like every other register.
- R6: `alu_func` selects the operation: 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 XOR; codes 5 to 7 give zero. The result is latched at the edge after the operand latches load, so it appears on `mem_addr` two edges after the source addresses are presented.
- R7: With `opb_imm` high, the second ALU operand is the extended immediate; with it low, it is the B operand latch.
- R8: With `imm_signed` high, the 16-bit `imm_field` is sign extended to 32 bits; with it low, it is zero extended.
- R9: `store_data` carries the B operand latch one edge later, so it shows register `src_b_sel` two edges after that address is presented.
- R10: `res_sel` picks the write-back source, which loads into the write-back latch at each edge: 0 the ALU result latch, 1 `mem_rdata`, 2 `ret_addr`, 3 the ALU result latch.
- R11: `eq_flag` is high exactly when the two operand latches hold equal values, one edge after the source addresses are presented.
- R12: Every pipeline latch loads at every rising edge, with no hold or enable.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a_sel | input | 5 | Number of the first source register |
| src_b_sel | input | 5 | Number of the second source register |
| dst_sel | input | 5 | Number of the destination register |
| wr_en | input | 1 | Write the write-back latch into the destination register |
| imm_field | input | 16 | Immediate field from the instruction |
| imm_signed | input | 1 | 1: sign extend the immediate, 0: zero extend |
| opb_imm | input | 1 | 1: second ALU operand is the immediate, 0: B operand latch |
| alu_func | input | 3 | ALU operation code |
| res_sel | input | 2 | Write-back source select |
| mem_rdata | input | 32 | Data read from memory |
| ret_addr | input | 32 | Return address for calls |
| mem_addr | output | 32 | ALU result latch, used as the memory address |
| store_data | output | 32 | Store-data latch |
| eq_flag | output | 1 | Operand latches are equal |

## Verification
Register contents can be seen only through the operand path. A wrong value written into the file, or a write that should not have happened, shows only when that register is read back: two edges later on `mem_addr` and `store_data`, and one edge later on `eq_flag`. The bench therefore reads back each register it writes through the ALU path with a zero immediate. A wrong select in the result mux or the immediate extender shows on the first read-back after the write, or on the very next ALU result. Read-during-write ordering is checked by watching `mem_addr` on two edges in a row.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_XOR = 3'd4
   } alu_op_e;

   typedef enum logic [1:0] {
      RES_ALU  = 2'd0,
      RES_MEM  = 2'd1,
      RES_RET  = 2'd2,
      RES_ALU2 = 2'd3
   } res_src_e;

   function automatic int clog2_min1(input int n);
      int r;
      r = 0;
      while ((1 << r) < n) r++;
      if (r == 0) r = 1;
      return r;
   endfunction

endpackage

// File: rtl/rsd_regfile.sv
module rsd_regfile #(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 32,
   localparam int ADDR_W = rsd_pkg::clog2_min1(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_a_addr,
   input  logic [ADDR_W-1:0] rd_b_addr,
   output logic [DATA_W-1:0] rd_a_data,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   generate
      if (REG_CNT < 2) begin : g_bad_cnt
         $error("rsd_regfile: REG_CNT must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("rsd_regfile: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] regs_q [REG_CNT];

   // read ports: combinational, old contents during a same-edge write
   always_comb begin
      rd_a_data = '0;
      rd_b_data = '0;
      if (int'(rd_a_addr) < REG_CNT) rd_a_data = regs_q[rd_a_addr];
      if (int'(rd_b_addr) < REG_CNT) rd_b_data = regs_q[rd_b_addr];
   end

   // one storage word per register, each with its own write decode
   for (genvar gi = 0; gi < REG_CNT; gi++) begin : g_reg
      logic hit;
      assign hit = wr_en && (int'(wr_addr) == gi);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   regs_q[gi] <= '0;
         else if (hit) regs_q[gi] <= wr_data;
      end
   end

endmodule

// File: rtl/rsd_imm_ext.sv
module rsd_imm_ext #(
   parameter int IMM_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic [IMM_W-1:0]  imm_in,
   input  logic              sign_mode,
   output logic [DATA_W-1:0] imm_out
);

   generate
      if (IMM_W > DATA_W) begin : g_bad
         $error("rsd_imm_ext: IMM_W may not exceed DATA_W");
      end
      if (IMM_W == DATA_W) begin : g_pass
         assign imm_out = imm_in;
      end else begin : g_ext
         localparam int PAD_W = DATA_W - IMM_W;
         logic fill;
         assign fill    = sign_mode & imm_in[IMM_W-1];
         assign imm_out = {{PAD_W{fill}}, imm_in};
      end
   endgenerate

endmodule

// File: rtl/rsd_alu.sv
module rsd_alu #(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        func,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] result
);
   import rsd_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad
         $error("rsd_alu: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] sum_w;
   logic [DATA_W-1:0] dif_w;

   assign sum_w = opa + opb;
   assign dif_w = opa - opb;

   always_comb begin
      unique case (func)
         ALU_ADD: result = sum_w;
         ALU_SUB: result = dif_w;
         ALU_AND: result = opa & opb;
         ALU_OR:  result = opa | opb;
         ALU_XOR: result = opa ^ opb;
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/rsd_datapath.sv
module rsd_datapath #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter int REG_CNT = 32,
   localparam int ADDR_W = rsd_pkg::clog2_min1(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] src_a_sel,
   input  logic [ADDR_W-1:0] src_b_sel,
   input  logic [ADDR_W-1:0] dst_sel,
   input  logic              wr_en,
   input  logic [IMM_W-1:0]  imm_field,
   input  logic              imm_signed,
   input  logic              opb_imm,
   input  logic [2:0]        alu_func,
   input  logic [1:0]        res_sel,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] ret_addr,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] store_data,
   output logic              eq_flag
);
   import rsd_pkg::*;

   generate
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("rsd_datapath: immediate wider than data path");
      end
   endgenerate

   logic [DATA_W-1:0] rd_a, rd_b;
   logic [DATA_W-1:0] ra_q, rb_q, rz_q, rm_q, ry_q;
   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] opb_mux;
   logic [DATA_W-1:0] alu_y;
   logic [DATA_W-1:0] res_mux;

   rsd_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_a_addr (src_a_sel),
      .rd_b_addr (src_b_sel),
      .rd_a_data (rd_a),
      .rd_b_data (rd_b),
      .wr_en     (wr_en),
      .wr_addr   (dst_sel),
      .wr_data   (ry_q)
   );

   rsd_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_imm (
      .imm_in    (imm_field),
      .sign_mode (imm_signed),
      .imm_out   (imm_ext)
   );

   assign opb_mux = opb_imm ? imm_ext : rb_q;

   rsd_alu #(.DATA_W(DATA_W)) u_alu (
      .func   (alu_func),
      .opa    (ra_q),
      .opb    (opb_mux),
      .result (alu_y)
   );

   always_comb begin
      unique case (res_src_e'(res_sel))
         RES_MEM: res_mux = mem_rdata;
         RES_RET: res_mux = ret_addr;
         default: res_mux = rz_q;
      endcase
   end

   // interstage latches: no enable, load every edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra_q <= '0;
         rb_q <= '0;
         rz_q <= '0;
         rm_q <= '0;
         ry_q <= '0;
      end else begin
         ra_q <= rd_a;
         rb_q <= rd_b;
         rz_q <= alu_y;
         rm_q <= rb_q;
         ry_q <= res_mux;
      end
   end

   assign mem_addr   = rz_q;
   assign store_data = rm_q;
   assign eq_flag    = (ra_q == rb_q);

endmodule

// File: rtl/rsd_datapath_chk.sv
module rsd_datapath_chk #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter int ADDR_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              opb_imm,
   input logic              imm_signed,
   input logic [IMM_W-1:0]  imm_field,
   input logic [2:0]        alu_func,
   input logic [1:0]        res_sel,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] ret_addr,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] store_data,
   input logic              eq_flag,
   input logic [DATA_W-1:0] rd_a,
   input logic [DATA_W-1:0] rd_b,
   input logic [DATA_W-1:0] ra_q,
   input logic [DATA_W-1:0] rb_q,
   input logic [DATA_W-1:0] ry_q,
   input logic [DATA_W-1:0] imm_ext
);

   // R11
   eq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (eq_flag == ($past(rd_a) == $past(rd_b))));

   // R9
   store_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |=> (store_data == $past(rd_b, 2)));

   // R10
   mem_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sel == 2'd1) |=> (ry_q == $past(mem_rdata)));

   // R10
   ret_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sel == 2'd2) |=> (ry_q == $past(ret_addr)));

   // R6
   add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_func == 3'd0 && !opb_imm) |=> (mem_addr == $past(ra_q) + $past(rb_q)));

   // R8
   sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_signed && imm_field[IMM_W-1]) |-> (&imm_ext[DATA_W-1:IMM_W]));

   // R8
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!imm_signed) |-> (imm_ext[DATA_W-1:IMM_W] == '0));

endmodule

bind rsd_datapath rsd_datapath_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .opb_imm    (opb_imm),
   .imm_signed (imm_signed),
   .imm_field  (imm_field),
   .alu_func   (alu_func),
   .res_sel    (res_sel),
   .mem_rdata  (mem_rdata),
   .ret_addr   (ret_addr),
   .mem_addr   (mem_addr),
   .store_data (store_data),
   .eq_flag    (eq_flag),
   .rd_a       (rd_a),
   .rd_b       (rd_b),
   .ra_q       (ra_q),
   .rb_q       (rb_q),
   .ry_q       (ry_q),
   .imm_ext    (imm_ext)
);

// File: tb/rsd_datapath_tb.sv
module rsd_datapath_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  src_a_sel = '0, src_b_sel = '0, dst_sel = '0;
   logic        wr_en = 1'b0;
   logic [15:0] imm_field = '0;
   logic        imm_signed = 1'b0, opb_imm = 1'b0;
   logic [2:0]  alu_func = '0;
   logic [1:0]  res_sel = '0;
   logic [31:0] mem_rdata = '0, ret_addr = '0;
   logic [31:0] mem_addr, store_data;
   logic        eq_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rsd_datapath u_dut (
      .clk(clk), .rst_n(rst_n), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
      .dst_sel(dst_sel), .wr_en(wr_en), .imm_field(imm_field),
      .imm_signed(imm_signed), .opb_imm(opb_imm), .alu_func(alu_func),
      .res_sel(res_sel), .mem_rdata(mem_rdata), .ret_addr(ret_addr),
      .mem_addr(mem_addr), .store_data(store_data), .eq_flag(eq_flag)
   );

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [2:0]  f;
      logic        bi;
      logic [15:0] imm;
      logic        sx;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{32'd7,        32'd5,        3'd0, 1'b0, 16'h0000, 1'b0},
      '{32'd7,        32'd9,        3'd1, 1'b0, 16'h0000, 1'b0},
      '{32'hF0F0_1234, 32'h0FF0_FF00, 3'd2, 1'b0, 16'h0000, 1'b0},
      '{32'hF0F0_1234, 32'h0FF0_FF00, 3'd3, 1'b0, 16'h0000, 1'b0},
      '{32'hAAAA_5555, 32'hAAAA_5555, 3'd4, 1'b0, 16'h0000, 1'b0},
      '{32'd100,      32'd3,        3'd0, 1'b1, 16'hFFFC, 1'b1},
      '{32'd100,      32'd3,        3'd0, 1'b1, 16'hFFFC, 1'b0},
      '{32'h1234_0000, 32'd1,        3'd3, 1'b1, 16'h8001, 1'b1},
      '{32'hFFFF_FFFF, 32'd1,        3'd0, 1'b0, 16'h0000, 1'b0},
      '{32'h1111_1111, 32'h2222_2222, 3'd6, 1'b0, 16'h0000, 1'b0}
   };

   function automatic logic [31:0] ext16(input logic [15:0] v, input logic sx);
      return sx ? {{16{v[15]}}, v} : {16'h0000, v};
   endfunction

   function automatic logic [31:0] model(input vec_t v);
      logic [31:0] opb;
      opb = v.bi ? ext16(v.imm, v.sx) : v.b;
      case (v.f)
         3'd0: return v.a + opb;
         3'd1: return v.a - opb;
         3'd2: return v.a & opb;
         3'd3: return v.a | opb;
         3'd4: return v.a ^ opb;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // write val into register r through the return-address write-back path
   task automatic load_reg(input logic [4:0] r, input logic [31:0] val);
      wr_en = 1'b0; res_sel = 2'd2; ret_addr = val;
      tick(1);
      dst_sel = r; wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
   endtask

   // read register r through ADD with a zero immediate
   task automatic read_reg(input logic [4:0] r, output logic [31:0] val);
      wr_en = 1'b0; src_a_sel = r; alu_func = 3'd0; opb_imm = 1'b1;
      imm_field = 16'h0; imm_signed = 1'b0;
      tick(2);
      val = mem_addr;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      tick(3);
      // R1: reset state
      check32("R1 mem_addr", mem_addr, 32'h0);
      check32("R1 store_data", store_data, 32'h0);
      check32("R1 eq_flag", {31'h0, eq_flag}, 32'h1);
      rst_n = 1'b1;
      tick(1);
      read_reg(5'd17, rv);
      check32("R1 register cleared", rv, 32'h0);

      // R2 R6 R7 R8 R9 R11 R12: vector table
      for (int i = 0; i < NV; i++) begin
         load_reg(5'd1, VEC[i].a);
         load_reg(5'd2, VEC[i].b);
         src_a_sel = 5'd1; src_b_sel = 5'd2;
         alu_func = VEC[i].f; opb_imm = VEC[i].bi;
         imm_field = VEC[i].imm; imm_signed = VEC[i].sx;
         tick(1);
         check32("R11 eq_flag", {31'h0, eq_flag}, {31'h0, VEC[i].a == VEC[i].b});
         tick(1);
         check32("R6 alu result", mem_addr, model(VEC[i]));
         check32("R9 store_data", store_data, VEC[i].b);
      end

      // R10: ALU write-back (select 0) and alias select 3
      load_reg(5'd1, 32'd40);
      load_reg(5'd2, 32'd2);
      src_a_sel = 5'd1; src_b_sel = 5'd2; alu_func = 3'd1; opb_imm = 1'b0;
      res_sel = 2'd0;
      tick(3);
      dst_sel = 5'd4; wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
      read_reg(5'd4, rv);
      check32("R10 alu select", rv, 32'd38);
      src_a_sel = 5'd1; src_b_sel = 5'd2; alu_func = 3'd0; opb_imm = 1'b0;
      res_sel = 2'd3;
      tick(3);
      dst_sel = 5'd8; wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
      read_reg(5'd8, rv);
      check32("R10 select 3", rv, 32'd42);

      // R10: memory data select
      res_sel = 2'd1; mem_rdata = 32'hDEAD_BEEF;
      tick(1);
      dst_sel = 5'd6; wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
      read_reg(5'd6, rv);
      check32("R10 memory select", rv, 32'hDEAD_BEEF);

      // R5: register 0 is writable
      load_reg(5'd0, 32'h0BAD_F00D);
      read_reg(5'd0, rv);
      check32("R5 register 0", rv, 32'h0BAD_F00D);

      // R3: write enable low leaves the register alone
      load_reg(5'd3, 32'h3333_3333);
      res_sel = 2'd2; ret_addr = 32'h9999_9999; dst_sel = 5'd3; wr_en = 1'b0;
      tick(4);
      read_reg(5'd3, rv);
      check32("R3 no write", rv, 32'h3333_3333);

      // R4: read during write sees old, then new
      load_reg(5'd5, 32'hAAAA_0001);
      res_sel = 2'd2; ret_addr = 32'hBBBB_0002;
      src_a_sel = 5'd5; alu_func = 3'd0; opb_imm = 1'b1; imm_field = 16'h0;
      tick(1);
      dst_sel = 5'd5; wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
      tick(0);
      check32("R4 old value", mem_addr, 32'hAAAA_0001);
      tick(1);
      check32("R4 new value", mem_addr, 32'hBBBB_0002);

      // R12: a change of function shows at the very next edge
      load_reg(5'd1, 32'h0000_00F0);
      src_a_sel = 5'd1; opb_imm = 1'b1; imm_field = 16'h000F; imm_signed = 1'b0;
      alu_func = 3'd3;
      tick(2);
      alu_func = 3'd2;
      tick(1);
      check32("R12 no hold", mem_addr, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule